// File: doc/BRIEF.md
# USB Endpoint Transmit Packet Buffer

This block holds outgoing packets for one USB device endpoint. Software pushes packet bytes one at a time into a load port and then writes an arm command to a small control and status register, which hands the packet to the transmit side. A transmit engine pulls the bytes out with a read strobe. It then reports the host's response as one of two strobes: an acknowledgement, which frees the buffer, or a timeout, which rewinds the packet so it is sent again.

The block keeps a load pointer and a read pointer for each of its two storage buffers. In single mode only one buffer is used. In double mode, software fills one buffer while the other is waiting for transmission or acknowledgement, and packets leave in the order they were armed.

A read-only has-data status bit is high while the load pointer of the buffer in focus is away from offset zero. That buffer is the oldest occupied one, or the load buffer when none is occupied. The bit stays high through readout until the host acknowledges the packet. A self-clearing flush command empties the buffer in focus. A flush issued when nothing is buffered is latched as a pending discard, which drops the next armed packet. Loads that do not fit raise a sticky overrun bit.

Top module: `usb_tx_pktbuf`

## Requirements
- R1: After reset the status register reads 0 and tx_valid_o is low.
- R2: Status bit 1 (has-data) is 1 exactly when the buffer in focus holds a loaded byte. Writing bit 1 has no effect on it.
- R3: Writing status bit 0 (arm) to a non-empty buffer raises tx_valid_o. Each tx_rd_i strobe then returns the loaded bytes in load order, with tx_last_o high on the final byte. Arming an empty buffer does nothing.
- R4: After readout, has-data stays 1 until tx_ack_i. An acknowledgement clears it and frees the buffer. An acknowledgement that arrives before readout is complete is ignored.
- R5: A tx_timeout_i strobe after readout keeps the packet and has-data. tx_valid_o rises again and the resend starts from the first byte.
- R6: Writing status bit 2 (flush) to a non-empty focus buffer discards its packet and clears has-data and tx_valid_o. Bit 2 reads 1 in the cycle after the write and 0 after that.
- R7: A flush while nothing is buffered sets status bit 4 (discard pending). The next non-empty packet that is armed is dropped without being transmitted, and bit 4 clears.
- R8: With dbl_mode_i high, a second packet can be loaded and armed while the first is outstanding, and the packets are transmitted in arm order.
- R9: In double mode one flush empties only the oldest occupied buffer, and a second flush empties the other.
- R10: A load into a buffer that is full (DEPTH bytes) or armed is dropped and sets status bit 3 (overrun). Writing 1 to bit 3 clears it.
- R11: In double mode, has-data reports the oldest armed buffer while one is outstanding, even though software is loading the other buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_mode_i | input | 1 | 1 selects two ping-pong buffers; change only while idle |
| ld_valid_i | input | 1 | Load strobe for one packet byte |
| ld_data_i | input | DW | Packet byte to load |
| csr_wr_i | input | 1 | Status/command register write strobe |
| csr_wdata_i | input | 5 | Write data: bit0 arm, bit2 flush, bit3 overrun clear |
| csr_rdata_o | output | 5 | bit1 has-data, bit2 flush readback, bit3 overrun, bit4 discard pending |
| tx_valid_o | output | 1 | A byte of the armed packet is available |
| tx_data_o | output | DW | Current transmit byte |
| tx_last_o | output | 1 | Current byte is the last of the packet |
| tx_rd_i | input | 1 | Transmit side consumes the current byte |
| tx_ack_i | input | 1 | Host acknowledged the transmitted packet |
| tx_timeout_i | input | 1 | No acknowledgement; resend the packet |

## Verification
The assertions check the following on every cycle:
- The pointers stay within the buffer, and the read pointer never passes the load pointer.
- An armed buffer is never empty.
- The transmit buffer and the load buffer coincide whenever the transmit buffer is idle.
- In single mode, has-data holds until an acknowledgement, a flush or an arm arrives, and an accepted acknowledgement frees the buffer.
- A flush, an overrun or a discard event is visible in the status register one cycle later.

Only the bench's scenarios can show the remaining behaviour:
- Byte order and the position of tx_last_o.
- A resend after a timeout starting from the first byte.
- A discard that was latched by an empty flush dropping the next packet.
- The two-flush sequence that empties double mode.

// File: rtl/usb_txbuf_pkg.sv
package usb_txbuf_pkg;
  localparam int NBUF  = 2;
  localparam int CSR_W = 5;
  // status/command bit positions
  localparam int B_ARM   = 0;
  localparam int B_HAS   = 1;
  localparam int B_FLUSH = 2;
  localparam int B_OVR   = 3;
  localparam int B_DPEND = 4;
endpackage

// File: rtl/usb_txbuf_bank.sv
module usb_txbuf_bank #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          arm_i,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic          rewind_i,
  output logic [PW-1:0] cnt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          last_o,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          busy;
  logic          full;

  assign full = (wptr == PW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (ld_i && !busy && !full && !clr_i) mem[wptr[AW-1:0]] <= ld_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      busy <= 1'b0;
    end else if (clr_i) begin
      wptr <= '0;
      rptr <= '0;
      busy <= 1'b0;
    end else begin
      if (ld_i && !busy && !full) wptr <= wptr + PW'(1);
      if (rewind_i) rptr <= '0;
      else if (rd_i && busy && rptr != wptr) rptr <= rptr + PW'(1);
      if (arm_i && !busy && wptr != '0) busy <= 1'b1;
    end
  end

  assign cnt_o     = wptr;
  assign busy_o    = busy;
  assign done_o    = busy && (rptr == wptr);
  assign last_o    = busy && ((rptr + PW'(1)) == wptr);
  assign rd_data_o = mem[rptr[AW-1:0]];

  AST_WPTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr <= PW'(DEPTH)); // R10
  AST_RPTR_LE_WPTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr <= wptr); // R3
  AST_BUSY_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> wptr != '0); // R4
endmodule

// File: rtl/usb_txbuf_csr.sv
module usb_txbuf_csr
  import usb_txbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_wr_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  input  logic             has_data_i,
  input  logic             ovf_evt_i,
  input  logic             dpend_set_i,
  input  logic             dpend_clr_i,
  output logic             arm_o,
  output logic             flush_o,
  output logic             dpend_o,
  output logic [CSR_W-1:0] csr_rdata_o
);
  logic flush_q, ovr_q, dpend_q, ovr_clr;

  assign arm_o   = csr_wr_i && csr_wdata_i[B_ARM];
  assign flush_o = csr_wr_i && csr_wdata_i[B_FLUSH];
  assign ovr_clr = csr_wr_i && csr_wdata_i[B_OVR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      ovr_q   <= 1'b0;
      dpend_q <= 1'b0;
    end else begin
      flush_q <= flush_o;
      if (ovf_evt_i)    ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
      if (dpend_set_i)      dpend_q <= 1'b1;
      else if (dpend_clr_i) dpend_q <= 1'b0;
    end
  end

  assign dpend_o = dpend_q;

  always_comb begin
    csr_rdata_o          = '0;
    csr_rdata_o[B_HAS]   = has_data_i;
    csr_rdata_o[B_FLUSH] = flush_q;
    csr_rdata_o[B_OVR]   = ovr_q;
    csr_rdata_o[B_DPEND] = dpend_q;
  end

  AST_FLUSH_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> csr_rdata_o[B_FLUSH]); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> csr_rdata_o[B_OVR]); // R10
  AST_DPEND_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpend_set_i |=> csr_rdata_o[B_DPEND]); // R7
endmodule

// File: rtl/usb_txbuf_ctrl.sv
module usb_txbuf_ctrl
  import usb_txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dbl_i,
  input  logic                     ld_i,
  input  logic                     arm_i,
  input  logic                     flush_i,
  input  logic                     dpend_i,
  input  logic                     ack_i,
  input  logic                     tmo_i,
  input  logic                     rd_i,
  input  logic [NBUF-1:0][PW-1:0]  cnt_i,
  input  logic [NBUF-1:0]          busy_i,
  input  logic [NBUF-1:0]          done_i,
  output logic [NBUF-1:0]          ld_o,
  output logic [NBUF-1:0]          arm_o,
  output logic [NBUF-1:0]          clr_o,
  output logic [NBUF-1:0]          rd_o,
  output logic [NBUF-1:0]          rew_o,
  output logic                     tx_sel_o,
  output logic                     has_data_o,
  output logic                     ovf_evt_o,
  output logic                     dpend_set_o,
  output logic                     dpend_clr_o
);
  logic sw_sel, tx_sel, acc_sel;
  logic sw_busy, sw_full, sw_empty;
  logic flush_hit, tx_ok, ack_ok, tmo_ok, arm_ok, hand, drop, ld_ok, tx_adv;

  // focus: oldest occupied buffer, else the load buffer
  assign acc_sel    = (cnt_i[tx_sel] != '0) ? tx_sel : sw_sel;
  assign has_data_o = (cnt_i[acc_sel] != '0);

  assign sw_busy  = busy_i[sw_sel];
  assign sw_full  = (cnt_i[sw_sel] == PW'(DEPTH));
  assign sw_empty = (cnt_i[sw_sel] == '0);

  assign flush_hit   = flush_i && has_data_o;
  assign dpend_set_o = flush_i && !has_data_o;

  assign tx_ok  = busy_i[tx_sel] && done_i[tx_sel];
  assign ack_ok = ack_i && tx_ok && !flush_hit;
  assign tmo_ok = tmo_i && !ack_i && tx_ok && !flush_hit;

  assign arm_ok = arm_i && !sw_busy && !sw_empty && !(flush_hit && acc_sel == sw_sel);
  assign drop   = arm_ok && dpend_i;
  assign hand   = arm_ok && !dpend_i;
  assign dpend_clr_o = drop;

  assign ld_ok     = ld_i && !sw_busy && !sw_full;
  assign ovf_evt_o = ld_i && !ld_ok;

  assign tx_adv = ack_ok || (flush_hit && busy_i[tx_sel]);

  for (genvar b = 0; b < NBUF; b++) begin : g_route
    assign ld_o[b]  = ld_ok && (sw_sel == 1'(b));
    assign arm_o[b] = hand && (sw_sel == 1'(b));
    assign clr_o[b] = (flush_hit && acc_sel == 1'(b)) ||
                      (ack_ok && tx_sel == 1'(b)) ||
                      (drop && sw_sel == 1'(b));
    assign rd_o[b]  = rd_i && (tx_sel == 1'(b));
    assign rew_o[b] = tmo_ok && (tx_sel == 1'(b));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_sel <= 1'b0;
      tx_sel <= 1'b0;
    end else if (!dbl_i) begin
      sw_sel <= 1'b0;
      tx_sel <= 1'b0;
    end else begin
      if (hand)   sw_sel <= ~sw_sel;
      if (tx_adv) tx_sel <= ~tx_sel;
    end
  end

  assign tx_sel_o = tx_sel;

  AST_SEL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i[tx_sel] |-> tx_sel == sw_sel); // R8
  AST_HAS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_i && has_data_o && !ack_i && !flush_i && !arm_i) |=> has_data_o); // R4
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_i && ack_ok) |=> !busy_i[0]); // R4
endmodule

// File: rtl/usb_tx_pktbuf.sv
module usb_tx_pktbuf
  import usb_txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_mode_i,
  input  logic             ld_valid_i,
  input  logic [DW-1:0]    ld_data_i,
  input  logic             csr_wr_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  output logic             tx_valid_o,
  output logic [DW-1:0]    tx_data_o,
  output logic             tx_last_o,
  input  logic             tx_rd_i,
  input  logic             tx_ack_i,
  input  logic             tx_timeout_i
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [NBUF-1:0]         b_ld, b_arm, b_clr, b_rd, b_rew, b_busy, b_done, b_last;
  logic [NBUF-1:0][PW-1:0] b_cnt;
  logic [NBUF-1:0][DW-1:0] b_dat;
  logic tx_sel, has_data, ovf_evt, dpend_set, dpend_clr, dpend;
  logic arm_cmd, flush_cmd;

  for (genvar g = 0; g < NBUF; g++) begin : g_bank
    usb_txbuf_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (b_ld[g]),
      .ld_data_i (ld_data_i),
      .arm_i     (b_arm[g]),
      .clr_i     (b_clr[g]),
      .rd_i      (b_rd[g]),
      .rewind_i  (b_rew[g]),
      .cnt_o     (b_cnt[g]),
      .busy_o    (b_busy[g]),
      .done_o    (b_done[g]),
      .last_o    (b_last[g]),
      .rd_data_o (b_dat[g])
    );
  end

  usb_txbuf_csr u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_wr_i    (csr_wr_i),
    .csr_wdata_i (csr_wdata_i),
    .has_data_i  (has_data),
    .ovf_evt_i   (ovf_evt),
    .dpend_set_i (dpend_set),
    .dpend_clr_i (dpend_clr),
    .arm_o       (arm_cmd),
    .flush_o     (flush_cmd),
    .dpend_o     (dpend),
    .csr_rdata_o (csr_rdata_o)
  );

  usb_txbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dbl_i       (dbl_mode_i),
    .ld_i        (ld_valid_i),
    .arm_i       (arm_cmd),
    .flush_i     (flush_cmd),
    .dpend_i     (dpend),
    .ack_i       (tx_ack_i),
    .tmo_i       (tx_timeout_i),
    .rd_i        (tx_rd_i),
    .cnt_i       (b_cnt),
    .busy_i      (b_busy),
    .done_i      (b_done),
    .ld_o        (b_ld),
    .arm_o       (b_arm),
    .clr_o       (b_clr),
    .rd_o        (b_rd),
    .rew_o       (b_rew),
    .tx_sel_o    (tx_sel),
    .has_data_o  (has_data),
    .ovf_evt_o   (ovf_evt),
    .dpend_set_o (dpend_set),
    .dpend_clr_o (dpend_clr)
  );

  assign tx_valid_o = b_busy[tx_sel] && !b_done[tx_sel];
  assign tx_data_o  = b_dat[tx_sel];
  assign tx_last_o  = tx_valid_o && b_last[tx_sel];

  AST_TXV_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> csr_rdata_o[B_HAS]); // R11
endmodule

// File: tb/usb_tx_pktbuf_bench.sv
module usb_tx_pktbuf_bench;
  import usb_txbuf_pkg::*;
  localparam int DEPTH = 8;
  localparam int DW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic dbl = 0, ld_v = 0, csr_wr = 0, tx_rd = 0, tx_ack = 0, tx_tmo = 0;
  logic [DW-1:0] ld_d = '0;
  logic [CSR_W-1:0] csr_wd = '0, csr_rd;
  logic tx_valid, tx_last;
  logic [DW-1:0] tx_data;

  usb_tx_pktbuf #(.DEPTH(DEPTH), .DW(DW)) u_usb_tx_pktbuf (
    .clk_i(clk), .rst_ni(rst_n), .dbl_mode_i(dbl),
    .ld_valid_i(ld_v), .ld_data_i(ld_d),
    .csr_wr_i(csr_wr), .csr_wdata_i(csr_wd), .csr_rdata_o(csr_rd),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_rd_i(tx_rd), .tx_ack_i(tx_ack), .tx_timeout_i(tx_tmo)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] pk [2][DEPTH];
  int pl [2];

  task automatic check(string r, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  function automatic int bit_of(int b);
    return int'(csr_rd[b]);
  endfunction

  function automatic int exp_last(int i, int n);
    return (i == n - 1) ? 1 : 0;
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ld(logic [DW-1:0] d);
    ld_v = 1; ld_d = d; cyc(); ld_v = 0;
  endtask

  task automatic csr_w(logic [CSR_W-1:0] v);
    csr_wr = 1; csr_wd = v; cyc(); csr_wr = 0; csr_wd = '0;
  endtask

  task automatic ack();
    tx_ack = 1; cyc(); tx_ack = 0;
  endtask

  task automatic tmo();
    tx_tmo = 1; cyc(); tx_tmo = 0;
  endtask

  task automatic load_pkt(int k, int n);
    pl[k] = n;
    for (int i = 0; i < n; i++) begin
      pk[k][i] = DW'($urandom);
      ld(pk[k][i]);
    end
  endtask

  task automatic drain(int k, string r);
    for (int i = 0; i < pl[k]; i++) begin
      check(r, "valid", int'(tx_valid), 1);
      check(r, "data", int'(tx_data), int'(pk[k][i]));
      check(r, "last", int'(tx_last), exp_last(i, pl[k]));
      tx_rd = 1; cyc(); tx_rd = 0;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) cyc();
    check("R1", "csr", int'(csr_rd), 0);
    check("R1", "valid", int'(tx_valid), 0);
    rst_n = 1; cyc();

    // R2: read-only has-data
    csr_w(5'h02);
    check("R2", "ro write", bit_of(B_HAS), 0);
    pl[0] = 4; pk[0][0] = 8'h11; pk[0][1] = 8'h22; pk[0][2] = 8'h33; pk[0][3] = 8'h44;
    ld(pk[0][0]);
    check("R2", "has after load", bit_of(B_HAS), 1);
    csr_w(5'h00);
    check("R2", "ro clear", bit_of(B_HAS), 1);
    for (int i = 1; i < 4; i++) ld(pk[0][i]);
    check("R3", "valid before arm", int'(tx_valid), 0);
    csr_w(5'h01);
    check("R3", "valid after arm", int'(tx_valid), 1);
    ack();
    check("R4", "early ack valid", int'(tx_valid), 1);
    check("R4", "early ack data", int'(tx_data), 8'h11);
    drain(0, "R3");
    check("R4", "valid after read", int'(tx_valid), 0);
    check("R4", "has after read", bit_of(B_HAS), 1);
    tmo();
    check("R5", "has after tmo", bit_of(B_HAS), 1);
    drain(0, "R5");
    ack();
    check("R4", "has after ack", bit_of(B_HAS), 0);
    check("R4", "valid after ack", int'(tx_valid), 0);
    csr_w(5'h01);
    check("R3", "arm empty", int'(tx_valid), 0);

    // R6 flush with data
    ld(8'hA1); ld(8'hA2);
    csr_w(5'h04);
    check("R6", "has after flush", bit_of(B_HAS), 0);
    check("R6", "flush rb", bit_of(B_FLUSH), 1);
    check("R6", "no pend", bit_of(B_DPEND), 0);
    cyc();
    check("R6", "flush rb clr", bit_of(B_FLUSH), 0);
    csr_w(5'h01);
    check("R6", "nothing left", int'(tx_valid), 0);

    // R7 flush while empty
    csr_w(5'h04);
    check("R7", "pend set", bit_of(B_DPEND), 1);
    ld(8'hB1); ld(8'hB2);
    check("R7", "has loaded", bit_of(B_HAS), 1);
    csr_w(5'h01);
    check("R7", "dropped valid", int'(tx_valid), 0);
    check("R7", "dropped has", bit_of(B_HAS), 0);
    check("R7", "pend clr", bit_of(B_DPEND), 0);
    load_pkt(0, 1);
    csr_w(5'h01);
    drain(0, "R7");
    ack();

    // R10 overrun
    load_pkt(0, DEPTH);
    check("R10", "no ovr yet", bit_of(B_OVR), 0);
    ld(8'hEE);
    check("R10", "ovr full", bit_of(B_OVR), 1);
    csr_w(5'h08);
    check("R10", "ovr clr", bit_of(B_OVR), 0);
    csr_w(5'h01);
    ld(8'hDD);
    check("R10", "ovr armed", bit_of(B_OVR), 1);
    csr_w(5'h08);
    drain(0, "R10");
    ack();

    // R8 / R11 double mode
    dbl = 1; cyc();
    load_pkt(0, 3); csr_w(5'h01);
    check("R11", "has armed", bit_of(B_HAS), 1);
    load_pkt(1, 2);
    check("R11", "has focus", bit_of(B_HAS), 1);
    csr_w(5'h01);
    drain(0, "R8"); ack();
    check("R11", "has second", bit_of(B_HAS), 1);
    drain(1, "R8"); ack();
    check("R8", "idle has", bit_of(B_HAS), 0);

    // R9 double flush
    load_pkt(0, 2); csr_w(5'h01);
    load_pkt(1, 2); csr_w(5'h01);
    csr_w(5'h04);
    check("R9", "has after one", bit_of(B_HAS), 1);
    check("R9", "second data", int'(tx_data), int'(pk[1][0]));
    csr_w(5'h04);
    check("R9", "has after two", bit_of(B_HAS), 0);
    check("R9", "valid after two", int'(tx_valid), 0);
    check("R9", "no pend", bit_of(B_DPEND), 0);
    dbl = 0; cyc(); cyc();

    // random mix
    for (int it = 0; it < 40; it++) begin
      dbl = 1'($urandom); cyc();
      load_pkt(0, 1 + int'($urandom % DEPTH)); csr_w(5'h01);
      if (dbl) begin
        load_pkt(1, 1 + int'($urandom % DEPTH)); csr_w(5'h01);
      end
      drain(0, dbl ? "R8" : "R3");
      if ($urandom % 3 == 0) begin
        tmo();
        check("R5", "rnd has", bit_of(B_HAS), 1);
        drain(0, "R5");
      end
      ack();
      if (dbl) begin
        drain(1, "R8");
        ack();
      end
      check("R4", "rnd idle", bit_of(B_HAS), 0);
      check("R10", "rnd ovr", bit_of(B_OVR), 0);
    end
    dbl = 0; cyc();
    finish_run();
  end
endmodule